// File: doc/BRIEF.md
# Reference Switch Phase-Step Corrector

This block sits between a pair of reference event streams and a digital PLL, all in one fast system clock domain. It passes the selected reference through a programmable delay and presents the delayed pulse to the PLL as a virtual reference. When the reference selection changes, the block raises a holdover flag so that the PLL stops following the virtual reference. It then measures how far the newly selected reference sits from the PLL feedback pulse and reloads the delay. After the reload, the virtual reference stays at the phase the PLL already follows, and the switch causes no phase step.

Delays and measurements are counted in system clock cycles. The nominal reference period is supplied as an input in cycles, and the block needs no divider. Measurements are always shorter than two periods, so a single conditional subtraction gives the phase modulo the period. When the corrector is disabled, the delay is forced to zero, and a switch passes its phase step straight to the PLL.

Top module: `refsw_phase_corrector`

## Requirements
- R1: With an effective delay of zero, a pulse on the selected reference (`ref_b` when `use_b` is 1, `ref_a` when `use_b` is 0) appears on `vref_pulse` in the same cycle. A pulse on the unselected reference never produces a `vref_pulse`.
- R2: With a loaded delay D > 0, a selected reference pulse in cycle t produces exactly one `vref_pulse`, in cycle t+D.
- R3: While `corr_en` is 1, a change of `use_b` seen in Normal asserts `holdover` from the next cycle onward.
- R4: In holdover the block waits for an `fb_pulse`. It then counts m, the number of cycles from that feedback pulse to the next selected reference pulse, and `holdover` stays 1 up to and including the cycle of that reference pulse.
- R5: The pulse that ends a measurement loads `delay_cyc` = (P − (m mod P)) mod P, where P is `nom_period`. The new value is visible in the next cycle, and `holdover` returns to 0 in that same cycle.
- R6: The reference pulse that ends a measurement is itself delayed by the newly loaded value. Its `vref_pulse` therefore falls P·⌈m/P⌉ cycles after the feedback pulse, which is on the feedback phase.
- R7: If m reaches 2P with no selected reference pulse, `meas_err` is 1 from the next cycle and `holdover` stays 1. `meas_err` returns to 0 in the cycle after the next selected reference pulse. A further `fb_pulse` then starts a new measurement.
- R8: A change of `use_b` during a measurement discards it and keeps `holdover` at 1. The next `fb_pulse` starts a fresh measurement, and only that measurement sets the delay.
- R9: While `corr_en` is 0, selected pulses pass in the same cycle. `delay_cyc` reads 0 from the next cycle, and a change of `use_b` leaves `holdover` at 0.
- R10: During and right after reset, `vref_pulse`, `holdover` and `meas_err` are 0 and `delay_cyc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a | input | 1 | Event pulse of reference A |
| ref_b | input | 1 | Event pulse of reference B |
| use_b | input | 1 | Reference selection: 1 picks B, 0 picks A |
| corr_en | input | 1 | Enables phase-step correction |
| fb_pulse | input | 1 | PLL feedback event pulse |
| nom_period | input | 16 | Nominal reference period in clock cycles |
| vref_pulse | output | 1 | Virtual reference pulse to the PLL |
| holdover | output | 1 | Tells the PLL to ignore the virtual reference |
| meas_err | output | 1 | Measurement window expired without a reference pulse |
| delay_cyc | output | 16 | Current delay-line setting in clock cycles |

## Verification
The bench builds the block with its default 16-bit width and drives `nom_period` with small values (5 and 12 cycles). With these periods, every feedback-to-reference offset from 1 to 2P−1 can be swept. The sweep covers the zero-delay point at m = P and the wrap above P. With the short windows, the timeout at 2P, the restart on a second switch and the disabled path each take only a few dozen cycles to reach.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL = 2'd0,
      ST_HOLD   = 2'd1,
      ST_MEAS   = 2'd2
   } refsw_state_e;
endpackage

// File: rtl/refsw_delay_line.sv
module refsw_delay_line #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         trig,
   input  logic [W-1:0] dly,
   output logic         pulse
);
   logic [W-1:0] rem_q;
   logic         busy_q;
   logic         zero_dly;

   assign zero_dly = (dly == '0);
   assign pulse    = (trig && zero_dly) || (busy_q && rem_q == W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         busy_q <= 1'b0;
      end else if (trig && !zero_dly) begin
         rem_q  <= dly;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         rem_q  <= rem_q - W'(1);
         if (rem_q == W'(1)) busy_q <= 1'b0;
      end
   end

   // R2: a running countdown never sits at zero
   p_count_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> rem_q != '0);
   // R2: the countdown steps by one each cycle unless it is reloaded
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && rem_q != W'(1) && !trig) |=> (busy_q && rem_q == $past(rem_q) - W'(1)));
endmodule

// File: rtl/refsw_phase_meter.sv
module refsw_phase_meter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         run,
   input  logic [W-1:0] period,
   output logic         expired,
   output logic [W-1:0] new_dly
);
   localparam int CW = W + 1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;
   logic [CW-1:0] per_x;
   logic [CW-1:0] resid;

   assign per_x   = {1'b0, period};
   assign limit   = {period, 1'b0};
   assign expired = run && (cnt_q >= limit);
   assign resid   = (cnt_q >= per_x) ? cnt_q - per_x : cnt_q;
   assign new_dly = (resid == '0) ? '0 : W'(per_x - resid);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (start)                  cnt_q <= CW'(1);
      else if (run && cnt_q < limit)   cnt_q <= cnt_q + CW'(1);
   end

   // R7: the measurement count never passes the two-period window
   p_cnt_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $stable(period) && cnt_q <= limit) |=> (cnt_q <= limit || !run || start));
endmodule

// File: rtl/refsw_switch_fsm.sv
module refsw_switch_fsm
   import refsw_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         sel_change,
   input  logic         fb_evt,
   input  logic         ref_evt,
   input  logic         expired,
   output refsw_state_e state,
   output logic         start,
   output logic         load,
   output logic         err
);
   refsw_state_e st_q, st_d;
   logic         err_q, err_d;

   assign state = st_q;
   assign err   = err_q;
   assign start = en && st_q == ST_HOLD && !sel_change && fb_evt;
   assign load  = en && st_q == ST_MEAS && !sel_change && !expired && ref_evt;

   always_comb begin
      st_d  = st_q;
      err_d = err_q;
      if (!en) begin
         st_d  = ST_NORMAL;
         err_d = 1'b0;
      end else begin
         if (ref_evt) err_d = 1'b0;
         unique case (st_q)
            ST_NORMAL: if (sel_change) st_d = ST_HOLD;
            ST_HOLD:   if (start) st_d = ST_MEAS;
            ST_MEAS: begin
               if (sel_change)   st_d = ST_HOLD;
               else if (expired) begin
                  st_d  = ST_HOLD;
                  err_d = 1'b1;
               end else if (ref_evt) st_d = ST_NORMAL;
            end
            default: st_d = ST_NORMAL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_NORMAL;
         err_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         err_q <= err_d;
      end
   end

   // R3: a switch seen in Normal with correction on enters holdover
   p_switch_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && st_q == ST_NORMAL && sel_change) |=> st_q == ST_HOLD);
   // R9: correction off always lands in Normal
   p_off_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> st_q == ST_NORMAL);
   // R8: a switch during a measurement returns to holdover
   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && st_q == ST_MEAS && sel_change) |=> st_q == ST_HOLD);
   // R7: an error flag only exists outside Normal
   p_err_in_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> st_q != ST_NORMAL);
endmodule

// File: rtl/refsw_phase_corrector.sv
module refsw_phase_corrector
   import refsw_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ref_a,
   input  logic         ref_b,
   input  logic         use_b,
   input  logic         corr_en,
   input  logic         fb_pulse,
   input  logic [W-1:0] nom_period,
   output logic         vref_pulse,
   output logic         holdover,
   output logic         meas_err,
   output logic [W-1:0] delay_cyc
);
   generate
      if (W < 4) begin : g_bad_width
         $error("refsw_phase_corrector: W must be at least 4");
      end
   endgenerate

   logic         sel_q;
   logic         sel_change;
   logic         ref_evt;
   logic         expired;
   logic         start;
   logic         load;
   logic         err;
   logic [W-1:0] new_dly;
   logic [W-1:0] dly_q;
   logic [W-1:0] dly_eff;
   refsw_state_e state;

   assign ref_evt    = use_b ? ref_b : ref_a;
   assign sel_change = use_b ^ sel_q;
   assign dly_eff    = !corr_en ? '0 : (load ? new_dly : dly_q);
   assign holdover   = (state != ST_NORMAL);
   assign meas_err   = err;
   assign delay_cyc  = dly_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         dly_q <= '0;
      end else begin
         sel_q <= use_b;
         if (!corr_en)  dly_q <= '0;
         else if (load) dly_q <= new_dly;
      end
   end

   refsw_switch_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (corr_en),
      .sel_change (sel_change),
      .fb_evt     (fb_pulse),
      .ref_evt    (ref_evt),
      .expired    (expired),
      .state      (state),
      .start      (start),
      .load       (load),
      .err        (err)
   );

   refsw_phase_meter #(.W(W)) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .run     (state == ST_MEAS),
      .period  (nom_period),
      .expired (expired),
      .new_dly (new_dly)
   );

   refsw_delay_line #(.W(W)) u_dline (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (ref_evt),
      .dly   (dly_eff),
      .pulse (vref_pulse)
   );

   // R5: a freshly loaded delay is below the nominal period
   p_load_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && corr_en && nom_period != '0) |=> (delay_cyc < nom_period));
   // R9: correction off clears the delay by the next cycle
   p_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !corr_en |=> delay_cyc == '0);
   // R7: an error flag implies holdover at the boundary
   p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      meas_err |-> holdover);
endmodule

// File: tb/refsw_phase_corrector_tb.sv
module refsw_phase_corrector_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_a = 1'b0, ref_b = 1'b0, use_b = 1'b0, corr_en = 1'b1, fb_pulse = 1'b0;
   logic [15:0] nom_period = 16'd12;
   logic        vref_pulse, holdover, meas_err;
   logic [15:0] delay_cyc;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;
   int vcnt = 0;
   int vlast = -1;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   refsw_phase_corrector u_dut (
      .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .use_b(use_b),
      .corr_en(corr_en), .fb_pulse(fb_pulse), .nom_period(nom_period),
      .vref_pulse(vref_pulse), .holdover(holdover), .meas_err(meas_err),
      .delay_cyc(delay_cyc)
   );

   always @(posedge clk) cyc = cyc + 1;
   always @(negedge clk) if (rst_n && vref_pulse) begin
      vcnt  = vcnt + 1;
      vlast = cyc;
   end

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // drive pulses for one cycle, stop at the falling edge for sampling
   task automatic drive(input logic a, input logic b, input logic f);
      ref_a = a; ref_b = b; fb_pulse = f;
      @(negedge clk);
   endtask

   task automatic adv();
      @(posedge clk); #1;
      ref_a = 0; ref_b = 0; fb_pulse = 0;
   endtask

   task automatic pulse_sel(); drive(!use_b, use_b, 0); endtask
   task automatic pulse_other(); drive(use_b, !use_b, 0); endtask

   // switch, wait one holdover cycle, feedback; returns feedback cycle
   task automatic switch_and_fb(output int fcyc);
      use_b = ~use_b;
      drive(0, 0, 0); chk("R3 holdover before edge", holdover, 0); adv();
      drive(0, 0, 0); chk("R3 holdover after switch", holdover, 1); adv();
      fcyc = cyc; vcnt = 0;
      drive(0, 0, 1); adv();
   endtask

   task automatic measure(input int p, input int k);
      int fcyc, d, x, expv;
      nom_period = 16'(p);
      switch_and_fb(fcyc);
      repeat (k - 1) adv();
      pulse_sel(); chk("R4 holdover at event", holdover, 1); adv();
      d = (p - (k % p)) % p;
      drive(0, 0, 0);
      chk("R5 holdover released", holdover, 0);
      chk("R5 delay loaded", delay_cyc, d);
      adv();
      while (cyc <= fcyc + 2 * p + 1) adv();
      expv = fcyc + p * ((k + p - 1) / p);
      chk("R6 vref count", vcnt, 1);
      chk("R6 vref on feedback phase", vlast, expv);
      // steady delay check plus an ignored unselected pulse
      vcnt = 0; x = cyc;
      pulse_sel();
      if (d == 0) chk("R1 zero delay same cycle", vref_pulse, 1);
      adv();
      pulse_other(); adv();
      repeat (p + 2) adv();
      chk("R2 one vref per event", vcnt, 1);
      chk("R2 vref after delay", vlast, x + d);
   endtask

   initial begin
      int fcyc, x;
      // reset
      drive(0, 0, 0);
      chk("R10 vref in reset", vref_pulse, 0);
      chk("R10 holdover in reset", holdover, 0);
      chk("R10 err in reset", meas_err, 0);
      chk("R10 delay in reset", delay_cyc, 0);
      adv(); rst_n = 1; adv();
      drive(0, 0, 0);
      chk("R10 holdover after reset", holdover, 0);
      chk("R10 delay after reset", delay_cyc, 0);
      adv();

      // R1: zero delay pass, unselected ignored
      pulse_sel(); chk("R1 selected passes", vref_pulse, 1); adv();
      pulse_other(); chk("R1 unselected ignored", vref_pulse, 0); adv();

      // near-exhaustive offset sweeps for two periods
      for (int k = 1; k < 10; k++) measure(5, k);
      for (int k = 1; k < 24; k++) measure(12, k);

      // R7: timeout
      nom_period = 16'd8;
      switch_and_fb(fcyc);
      while (cyc < fcyc + 16) adv();
      drive(0, 0, 0); chk("R7 no error at window end", meas_err, 0); adv();
      drive(0, 0, 0);
      chk("R7 error after window", meas_err, 1);
      chk("R7 holdover kept", holdover, 1);
      adv(); repeat (3) adv();
      pulse_sel(); adv();
      drive(0, 0, 0);
      chk("R7 error cleared", meas_err, 0);
      chk("R7 still holdover", holdover, 1);
      adv();
      vcnt = 0; fcyc = cyc; drive(0, 0, 1); adv();
      repeat (2) adv();
      pulse_sel(); adv();
      drive(0, 0, 0); chk("R7 remeasure delay", delay_cyc, 5); chk("R7 normal again", holdover, 0); adv();
      repeat (20) adv();

      // R8: restart on a second switch during measurement
      nom_period = 16'd12;
      switch_and_fb(fcyc);
      repeat (2) adv();
      use_b = ~use_b; drive(0, 0, 0); adv();
      drive(0, 0, 0); chk("R8 holdover kept after restart", holdover, 1); adv();
      pulse_sel(); adv();   // would end the old measurement; now only in hold
      drive(0, 0, 0); chk("R8 old measurement discarded", holdover, 1); adv();
      vcnt = 0; fcyc = cyc; drive(0, 0, 1); adv();
      repeat (3) adv();
      pulse_sel(); adv();
      drive(0, 0, 0); chk("R8 fresh delay", delay_cyc, 8); adv();
      while (cyc <= fcyc + 14) adv();
      chk("R8 vref aligned", vlast, fcyc + 12);
      repeat (20) adv();

      // R9: disabled path
      corr_en = 0; drive(0, 0, 0); adv();
      drive(0, 0, 0); chk("R9 delay zero", delay_cyc, 0); adv();
      use_b = ~use_b; drive(0, 0, 0); adv();
      drive(0, 0, 0); chk("R9 no holdover", holdover, 0); adv();
      vcnt = 0; x = cyc;
      pulse_sel(); chk("R9 same-cycle pass", vref_pulse, 1); adv();
      repeat (4) adv();
      chk("R9 single vref", vcnt, 1);

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         miscompares++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule